// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block places incoming frame bytes into host-owned data buffers. Each buffer is described by one entry of a circular table. An entry holds a 16-bit control/status word, a 16-bit length and a 32-bit buffer address. Software arms an entry by setting its empty flag, along with the optional interrupt and wrap flags and the buffer address. The engine then fills each armed buffer with up to `BUF_BYTES` bytes. When it finishes an entry it writes the entry back: the empty flag is cleared, the length is recorded, the first and last markers are set, and, in the entry that ends a frame, the frame's class/error flags are stored. It then moves to the next entry.

The table lives inside the block and is loaded through a simple write port. A monitor port reads it back. Stored bytes leave the block on a registered byte-write port that carries the target address. The ring length is set by the wrap flag: after an entry carrying that flag, filling starts again at entry 0. If the engine reaches an entry that software has not yet returned, it discards the rest of the frame and flags the loss on a busy output.

Top module: `rxring_filler`

## Requirements
- R1: After reset every entry's status, length and address read as zero, `ring_pos` is 0, and `buf_we`, `busy` and `irq` are low.
- R2: A stored byte appears on `buf_byte` with `buf_we` high one cycle after it is accepted. `buf_addr` equals the entry's address plus the byte's offset in the buffer, counting from 0.
- R3: An entry is closed when `BUF_BYTES` bytes are stored in it or when it takes the frame's final byte. On close, its length field becomes the number of bytes stored and its empty flag (bit 15) becomes 0.
- R4: On close, bit 10 (first) is 1 only if the entry holds the frame's first byte, and bit 11 (last) is 1 only if it holds the frame's final byte.
- R5: The class/error field, bits 8 down to 0, is replaced by `rx_cls` only in the entry that holds the final byte. In every entry, bits 14, 13, 12 and 9 and the buffer address keep the values software wrote.
- R6: After closing an entry whose wrap flag (bit 13) is set, `ring_pos` returns to 0. After closing the entry at index `NUM_DESC-1` it also returns to 0. Otherwise it advances by one.
- R7: `irq` is high for exactly the cycle after an entry with the interrupt flag (bit 12) is closed, and is low otherwise.
- R8: A byte offered while the current entry's empty flag is 0 is not stored, and `busy` is high in the following cycle. Every later byte of that frame, up to and including the one marked `rx_eof`, is also discarded with `busy`, even if the entry is re-armed meanwhile. `ring_pos` does not move during this.
- R9: A configuration write loads the status word and address and clears the length. If the engine closes the same entry in the same cycle, the engine's write wins.
- R10: While `rx_valid` is low, no entry, `ring_pos`, `buf_we`, `busy` or `irq` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one table entry |
| cfg_idx | input | $clog2(NUM_DESC) | Entry to load |
| cfg_status | input | 16 | Status word to load |
| cfg_ptr | input | ADDR_W | Buffer address to load |
| mon_idx | input | $clog2(NUM_DESC) | Entry to read back |
| mon_status | output | 16 | Status word of `mon_idx` |
| mon_len | output | 16 | Length of `mon_idx` |
| mon_ptr | output | ADDR_W | Address of `mon_idx` |
| rx_valid | input | 1 | A frame byte is offered (always taken) |
| rx_byte | input | 8 | Frame byte |
| rx_eof | input | 1 | This byte is the frame's last |
| rx_cls | input | 9 | Class/error flags, sampled with `rx_eof` |
| buf_we | output | 1 | Buffer byte write |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_byte | output | 8 | Buffer byte data |
| ring_pos | output | $clog2(NUM_DESC) | Index of the entry being filled |
| busy | output | 1 | A byte was discarded last cycle |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench covers several frame shapes. One frame spans two buffers, so the class flags must land in the second entry only; a design that wrote them in every entry would corrupt the software pattern in the first. One frame fills its buffer exactly, so the entry must carry both markers and a full length; an off-by-one closing rule would either open an empty entry or report a short length. One frame crosses the wrap entry into an unreturned entry, where a faulty engine would overwrite host-owned memory or stall the ring position. The bench also re-arms an entry in the middle of a discarded frame, to catch a design that resumes storing partway through. Finally, it loads an entry in the same cycle the engine closes it, to catch a design in which the configuration write overrides the engine's write-back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   // status word bit positions (bit 15 is the most significant)
   localparam int unsigned SB_EMPTY = 15;
   localparam int unsigned SB_WRAP  = 13;
   localparam int unsigned SB_IRQ   = 12;
   localparam int unsigned SB_LAST  = 11;
   localparam int unsigned SB_FIRST = 10;
   localparam int unsigned CLS_W    = 9;   // class/error field occupies [8:0]

   function automatic logic [15:0] close_word(input logic [15:0] old,
                                              input logic last,
                                              input logic first,
                                              input logic [CLS_W-1:0] cls);
      logic [15:0] w;
      w           = old;
      w[SB_EMPTY] = 1'b0;
      w[SB_LAST]  = last;
      w[SB_FIRST] = first;
      if (last) w[CLS_W-1:0] = cls;
      return w;
   endfunction
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
   parameter int NUM_DESC = 8,
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 16,
   localparam int IDX_W   = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [15:0]       cfg_status,
   input  logic [ADDR_W-1:0] cfg_ptr,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_idx,
   input  logic [15:0]       eng_status,
   input  logic [LEN_W-1:0]  eng_len,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [15:0]       rd_status,
   output logic [ADDR_W-1:0] rd_ptr,
   input  logic [IDX_W-1:0]  mon_idx,
   output logic [15:0]       mon_status,
   output logic [LEN_W-1:0]  mon_len,
   output logic [ADDR_W-1:0] mon_ptr
);
   import rxr_pkg::*;

   logic [15:0]       stat_q [NUM_DESC];
   logic [LEN_W-1:0]  len_q  [NUM_DESC];
   logic [ADDR_W-1:0] ptr_q  [NUM_DESC];

   generate
      for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat_q[g] <= '0;
               len_q[g]  <= '0;
               ptr_q[g]  <= '0;
            end else if (eng_we && eng_idx == IDX_W'(g)) begin
               stat_q[g] <= eng_status;   // engine write-back wins
               len_q[g]  <= eng_len;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
               stat_q[g] <= cfg_status;
               len_q[g]  <= '0;
               ptr_q[g]  <= cfg_ptr;
            end
         end
      end
   endgenerate

   assign rd_status  = stat_q[rd_idx];
   assign rd_ptr     = ptr_q[rd_idx];
   assign mon_status = stat_q[mon_idx];
   assign mon_len    = len_q[mon_idx];
   assign mon_ptr    = ptr_q[mon_idx];

   // R3: a closed entry is handed back with its empty flag cleared
   a_r3_empty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> !stat_q[$past(eng_idx)][SB_EMPTY]);

   // R9: the engine's length reaches the entry even under a colliding load
   a_r9_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_we && cfg_we && cfg_idx == eng_idx) |=> (len_q[$past(eng_idx)] == $past(eng_len)));
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl #(
   parameter int NUM_DESC    = 8,
   parameter int BUF_BYTES   = 4,
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter bit FOLD_AT_END = 1'b1,
   localparam int IDX_W      = $clog2(NUM_DESC),
   localparam int OFF_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_eof,
   input  logic [8:0]        rx_cls,
   input  logic [15:0]       cur_status,
   input  logic [ADDR_W-1:0] cur_ptr,
   output logic              eng_we,
   output logic [IDX_W-1:0]  eng_idx,
   output logic [15:0]       eng_status,
   output logic [LEN_W-1:0]  eng_len,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_byte,
   output logic              busy,
   output logic              irq
);
   import rxr_pkg::*;

   logic [IDX_W-1:0] idx_q, idx_nx;
   logic [OFF_W-1:0] off_q, off_inc;
   logic             infrm_q, hasfirst_q, drop_q;
   logic             take, discard, close, first_here;

   assign take       = rx_valid && !drop_q && cur_status[SB_EMPTY];
   assign discard    = rx_valid && !take;
   assign off_inc    = off_q + 1'b1;
   assign close      = take && (rx_eof || off_inc == OFF_W'(BUF_BYTES));
   assign first_here = hasfirst_q || !infrm_q;

   assign eng_we     = close;
   assign eng_idx    = idx_q;
   assign eng_status = close_word(cur_status, rx_eof, first_here, rx_cls);
   assign eng_len    = LEN_W'(off_inc);

   generate
      if (FOLD_AT_END) begin : g_fold
         assign idx_nx = (cur_status[SB_WRAP] || idx_q == IDX_W'(NUM_DESC - 1))
                         ? '0 : idx_q + 1'b1;
      end else begin : g_flag_only
         assign idx_nx = cur_status[SB_WRAP] ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         off_q      <= '0;
         infrm_q    <= 1'b0;
         hasfirst_q <= 1'b0;
         drop_q     <= 1'b0;
         buf_we     <= 1'b0;
         buf_addr   <= '0;
         buf_byte   <= '0;
         busy       <= 1'b0;
         irq        <= 1'b0;
      end else begin
         buf_we   <= take;
         buf_addr <= cur_ptr + ADDR_W'(off_q);
         buf_byte <= rx_byte;
         busy     <= discard;
         irq      <= close && cur_status[SB_IRQ];
         if (take) begin
            if (close) begin
               off_q      <= '0;
               idx_q      <= idx_nx;
               hasfirst_q <= 1'b0;
               infrm_q    <= !rx_eof;
            end else begin
               off_q      <= off_inc;
               hasfirst_q <= first_here;
               infrm_q    <= 1'b1;
            end
         end else if (discard) begin
            drop_q  <= !rx_eof;
            infrm_q <= 1'b0;
         end
      end
   end

   // R6: the ring position moves only on a close
   a_r6_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !close |=> (idx_q == $past(idx_q)));
   // R6: a close on a wrap-flagged entry restarts at entry 0
   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (close && cur_status[SB_WRAP]) |=> (idx_q == '0));
   // R8: a discarded byte never reaches the buffer port
   a_r8_busy_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);
   // R8: while a frame is being dropped nothing is stored
   a_r8_drop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q |=> !buf_we);
   // R3: the fill offset stays inside one buffer
   a_r3_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
      off_q < OFF_W'(BUF_BYTES));
endmodule

// File: rtl/rxring_filler.sv
module rxring_filler #(
   parameter int NUM_DESC    = 8,
   parameter int BUF_BYTES   = 4,
   parameter int ADDR_W      = 32,
   parameter bit FOLD_AT_END = 1'b1,
   localparam int IDX_W      = $clog2(NUM_DESC),
   localparam int LEN_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [15:0]       cfg_status,
   input  logic [ADDR_W-1:0] cfg_ptr,
   input  logic [IDX_W-1:0]  mon_idx,
   output logic [15:0]       mon_status,
   output logic [LEN_W-1:0]  mon_len,
   output logic [ADDR_W-1:0] mon_ptr,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_eof,
   input  logic [8:0]        rx_cls,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_byte,
   output logic [IDX_W-1:0]  ring_pos,
   output logic              busy,
   output logic              irq
);
   generate
      if (NUM_DESC < 2) begin : g_bad_depth
         $error("rxring_filler: NUM_DESC must be at least 2");
      end
      if (BUF_BYTES < 1 || BUF_BYTES > 65535) begin : g_bad_buf
         $error("rxring_filler: BUF_BYTES must fit the 16-bit length field");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("rxring_filler: ADDR_W too small");
      end
   endgenerate

   logic              eng_we;
   logic [IDX_W-1:0]  eng_idx;
   logic [15:0]       eng_status, cur_status;
   logic [LEN_W-1:0]  eng_len;
   logic [ADDR_W-1:0] cur_ptr;

   rxr_desc_ram #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_status(cfg_status), .cfg_ptr(cfg_ptr),
      .eng_we(eng_we), .eng_idx(eng_idx), .eng_status(eng_status), .eng_len(eng_len),
      .rd_idx(eng_idx), .rd_status(cur_status), .rd_ptr(cur_ptr),
      .mon_idx(mon_idx), .mon_status(mon_status), .mon_len(mon_len), .mon_ptr(mon_ptr)
   );

   rxr_fill_ctrl #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W),
                   .LEN_W(LEN_W), .FOLD_AT_END(FOLD_AT_END)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_cls(rx_cls),
      .cur_status(cur_status), .cur_ptr(cur_ptr),
      .eng_we(eng_we), .eng_idx(eng_idx), .eng_status(eng_status), .eng_len(eng_len),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_byte(buf_byte),
      .busy(busy), .irq(irq)
   );

   assign ring_pos = eng_idx;

   // R7: the interrupt request is a single-cycle pulse
   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |=> (!irq || $past(eng_we)));
endmodule

// File: tb/sim_rxring_filler.sv
module sim_rxring_filler;
   localparam int N   = 8;
   localparam int BUF = 4;

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0;
   logic [2:0]  cfg_idx = 0, mon_idx = 0;
   logic [15:0] cfg_status = 0;
   logic [31:0] cfg_ptr = 0;
   logic [15:0] mon_status, mon_len;
   logic [31:0] mon_ptr, buf_addr;
   logic        rx_valid = 0, rx_eof = 0;
   logic [7:0]  rx_byte = 0, buf_byte;
   logic [8:0]  rx_cls = 0;
   logic        buf_we, busy, irq;
   logic [2:0]  ring_pos;

   int n_cmp = 0, n_bad = 0;
   bit cmp_en = 0;

   rxring_filler u0 (.*);

   always #10 clk = ~clk;   // 50 MHz

   // reference model state
   logic [15:0] m_stat [N];
   int          m_len  [N];
   logic [31:0] m_ptr  [N];
   int  m_idx, m_off;
   bit  m_infrm, m_hasf, m_drop;
   bit  e_bwe, e_busy, e_irq;
   logic [31:0] e_baddr;
   logic [7:0]  e_bbyte;
   bit  closed, fh;
   int  cidx;
   logic [15:0] s;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_stat[i] = 0; m_len[i] = 0; m_ptr[i] = 0; end
         m_idx = 0; m_off = 0; m_infrm = 0; m_hasf = 0; m_drop = 0;
         e_bwe = 0; e_busy = 0; e_irq = 0; e_baddr = 0; e_bbyte = 0;
      end else begin
         e_bwe = 0; e_busy = 0; e_irq = 0; closed = 0; cidx = 0;
         if (rx_valid) begin
            if (m_drop || !m_stat[m_idx][15]) begin
               e_busy = 1; m_drop = !rx_eof; m_infrm = 0;
            end else begin
               fh = m_hasf || !m_infrm;
               e_bwe = 1; e_baddr = m_ptr[m_idx] + m_off; e_bbyte = rx_byte;
               if (rx_eof || m_off + 1 == BUF) begin
                  s = m_stat[m_idx];
                  s[15] = 0; s[11] = rx_eof; s[10] = fh;
                  if (rx_eof) s[8:0] = rx_cls;
                  m_stat[m_idx] = s; m_len[m_idx] = m_off + 1;
                  e_irq = s[12]; closed = 1; cidx = m_idx;
                  m_idx = (s[13] || m_idx == N - 1) ? 0 : m_idx + 1;
                  m_off = 0; m_hasf = 0; m_infrm = !rx_eof;
               end else begin
                  m_off++; m_hasf = fh; m_infrm = 1;
               end
            end
         end
         if (cfg_we && !(closed && cidx == int'(cfg_idx))) begin
            m_stat[cfg_idx] = cfg_status; m_len[cfg_idx] = 0; m_ptr[cfg_idx] = cfg_ptr;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk(buf_we == e_bwe, "R2 buf_we", 32'(buf_we), 32'(e_bwe));
         if (e_bwe) begin
            chk(buf_addr == e_baddr, "R2 buf_addr", buf_addr, e_baddr);
            chk(buf_byte == e_bbyte, "R2 buf_byte", 32'(buf_byte), 32'(e_bbyte));
         end
         chk(irq == e_irq, "R7 irq", 32'(irq), 32'(e_irq));
         chk(busy == e_busy, "R8 busy", 32'(busy), 32'(e_busy));
         chk(int'(ring_pos) == m_idx, "R6 ring_pos", 32'(ring_pos), 32'(m_idx));
      end
   end

   task automatic check_table(input string req);
      for (int i = 0; i < N; i++) begin
         mon_idx = 3'(i);
         #1;
         chk(mon_status == m_stat[i], req, 32'(mon_status), 32'(m_stat[i]));
         chk(int'(mon_len) == m_len[i], req, 32'(mon_len), 32'(m_len[i]));
         chk(mon_ptr == m_ptr[i], req, mon_ptr, m_ptr[i]);
      end
   endtask

   task automatic load(input int idx, input logic [15:0] st, input logic [31:0] p);
      @(negedge clk);
      cfg_we = 1; cfg_idx = 3'(idx); cfg_status = st; cfg_ptr = p;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic send(input int n, input logic [8:0] cls, input int base);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rx_valid = 1; rx_byte = 8'(base + k); rx_eof = (k == n - 1); rx_cls = cls;
      end
      @(negedge clk);
      rx_valid = 0; rx_eof = 0;
   endtask

   initial begin
      #(20 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(buf_we == 0 && busy == 0 && irq == 0, "R1 outputs", {29'd0, buf_we, busy, irq}, 0);
      chk(ring_pos == 0, "R1 ring_pos", 32'(ring_pos), 0);
      for (int i = 0; i < N; i++) m_stat[i] = 0;
      check_table("R1 table");
      rst_n = 1;
      @(negedge clk);
      cmp_en = 1;
      // arm entries 0..4: E=bit15, W=bit13 on 4, I=bit12 on 1 and 3, pattern 0x155 in [8:0]
      for (int i = 0; i < 5; i++)
         load(i, 16'h8000 | ((i == 4) ? 16'h2000 : 16'h0) |
                 ((i == 1 || i == 3) ? 16'h1000 : 16'h0) | 16'h0355,
              32'h1000 + 32'(i) * 32'h100);
      check_table("R9 load");
      send(6, 9'h0A1, 8'h10);              // two buffers, class only in second
      check_table("R3 R4 R5 split frame");
      send(4, 9'h1C3, 8'h30);              // exact fill
      send(1, 9'h007, 8'h50);              // single byte with interrupt
      check_table("R3 R4 exact and short");
      send(10, 9'h0FF, 8'h60);             // crosses wrap into unreturned entry
      check_table("R6 R8 wrap then overrun");
      // R10: idle inputs toggling with valid low
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); rx_byte = 8'(k * 37); rx_eof = k[0]; rx_cls = 9'(k * 51);
      end
      @(negedge clk); rx_eof = 0;
      check_table("R10 idle");
      load(0, 16'h8000, 32'h2000);
      load(1, 16'h9000, 32'h2100);
      send(3, 9'h111, 8'h80);
      send(5, 9'h022, 8'h90);              // entry 2 not returned: drop tail
      send(2, 9'h033, 8'hA0);              // whole frame dropped
      check_table("R8 drop");
      // R8: re-arm entry 2 in the middle of a dropped frame
      @(negedge clk); rx_valid = 1; rx_byte = 8'hB0; rx_eof = 0;
      @(negedge clk); rx_byte = 8'hB1; cfg_we = 1; cfg_idx = 2; cfg_status = 16'h8000; cfg_ptr = 32'h3000;
      @(negedge clk); cfg_we = 0; rx_byte = 8'hB2; rx_eof = 1;
      @(negedge clk); rx_valid = 0; rx_eof = 0;
      check_table("R8 rearm during drop");
      // R9: load colliding with the engine's close of the same entry
      @(negedge clk); rx_valid = 1; rx_byte = 8'hC0; rx_eof = 0; rx_cls = 9'h1AA;
      @(negedge clk); rx_byte = 8'hC1; rx_eof = 1;
      cfg_we = 1; cfg_idx = 2; cfg_status = 16'hFFFF; cfg_ptr = 32'hDEAD;
      @(negedge clk); rx_valid = 0; rx_eof = 0; cfg_we = 0;
      check_table("R9 collision");
      repeat (3) @(negedge clk);
      cmp_en = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule